// File: doc/BRIEF.md
# Branch Target Cache Controller

This block keeps a small direct-mapped cache of branch targets for an instruction fetch unit. The fetch stage presents a virtual fetch address on the lookup port and gets back, in the same cycle, a hit flag and the predicted target. No address translation happens on the way: the address selects an entry, and its upper bits are compared against the stored tag. When a branch resolves, the update port writes the entry or retires it. Every entry carries a privilege flag that records whether it was allocated in user mode or in supervisor mode.

A three-bit control word sets the cache up. Bit 0 turns prediction on. Bit 1 is a command that empties the whole cache. Bit 2 is a command that drops only the user-mode entries. A separate pulse input reports an instruction-cache invalidate or push, and that pulse also empties the cache.

The control side is a two-state machine. CTL_OFF is the reset state: the cache keeps accepting updates but never predicts. A control write with bit 0 set takes the transition OFF_TO_ON into CTL_ON, where lookups can hit. A control write with bit 0 clear takes the transition ON_TO_OFF back to CTL_OFF. Any other write leaves the state as it is. The clear commands act in the same cycle as the write, whatever the state.

Top module: `btc_ctrl`

## Requirements
- R1: After reset the enable bit reads as 0, every entry is invalid, and `ctl_rd_data` reads as 0.
- R2: `lk_hit` is 1 only while the enable bit (control bit 0) is set. A control write changes that bit from the next cycle on. While the bit is clear, lookups never hit, even on entries that are valid.
- R3: The entry index is fetch address bits [5:2] and the tag is bits [31:6]. `lk_hit` is combinational and is 1 when all of these hold: `lk_valid` is high, the block is enabled, the indexed entry is valid, and its tag matches. On a hit, `lk_target` is the stored target.
- R4: A control write with bit 1 set invalidates every entry from the next cycle on.
- R5: A control write with bit 2 set invalidates, from the next cycle on, every entry allocated with `up_user`=1. Entries allocated with `up_user`=0 stay valid and keep their targets.
- R6: `ctl_rd_data` bit 0 reflects the enable bit. Bits 1 and 2 always read as 0, including in the cycle after a write that set them.
- R7: A single write of 3'b011 leaves the cache both enabled and empty: the next lookups miss, and entries allocated after that write hit.
- R8: A pulse on `icache_inv` invalidates every entry from the next cycle on.
- R9: In any cycle that carries `icache_inv` or a control write with bit 1 or bit 2 set, `lk_hit` is 0.
- R10: An update with `up_taken`=1 writes tag, target, privilege flag and valid bit into the indexed entry, and the entry can hit from the next cycle on.
- R11: An update with `up_taken`=0 clears the valid bit of the indexed entry only if that entry is valid and its tag matches. Otherwise the update has no effect.
- R12: When an update and an invalidation fall in the same cycle, the invalidation is applied after the update. Clear-all or `icache_inv` leaves the new entry invalid. Clear-user keeps it only if `up_user`=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ctl_wr_en | input | 1 | Control write strobe |
| ctl_wr_data | input | 3 | Control word: bit0 enable, bit1 clear-all, bit2 clear-user |
| ctl_rd_data | output | 3 | Control readback: bit0 enable, bits 2:1 zero |
| icache_inv | input | 1 | Instruction-cache invalidate or push pulse |
| lk_valid | input | 1 | Lookup request |
| lk_addr | input | 32 | Virtual fetch address for the lookup |
| lk_hit | output | 1 | Lookup hit |
| lk_target | output | 32 | Predicted target |
| up_valid | input | 1 | Update request |
| up_addr | input | 32 | Address of the resolved branch |
| up_target | input | 32 | Resolved target |
| up_taken | input | 1 | Branch was taken |
| up_user | input | 1 | Branch ran in user mode |

## Verification
Two kinds of event can land on the same clock edge. The first is a lookup arriving together with an invalidation, whether that invalidation is a clear-all, a clear-user or an instruction-cache pulse. The second is an update arriving together with an invalidation. Random stimulus raises both collisions often, because it uses a tag space of four values and gives the clear commands and the invalidate pulse a small probability every cycle. Directed cases then force each collision against a known entry. In every cycle the bench compares the hit flag and the target with a reference model that applies the update first and the invalidation second, and that reports a miss whenever an invalidation is present.

// File: rtl/btc_pkg.sv
package btc_pkg;
    localparam int CTL_W            = 3;
    localparam int CTL_EN_BIT       = 0;
    localparam int CTL_CLR_ALL_BIT  = 1;
    localparam int CTL_CLR_USER_BIT = 2;

    typedef enum logic {
        CTL_OFF = 1'b0,
        CTL_ON  = 1'b1
    } ctl_state_e;
endpackage

// File: rtl/btc_ctl.sv
module btc_ctl
    import btc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CTL_W-1:0] wr_data,
    input  logic             icache_inv,
    output logic             enabled,
    output logic             flush_all,
    output logic             flush_user,
    output logic [CTL_W-1:0] rd_data
);
    ctl_state_e state_q;
    ctl_state_e state_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CTL_OFF;
        else        state_q <= state_d;
    end

    // Next state: OFF_TO_ON and ON_TO_OFF
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CTL_OFF: if (wr_en && wr_data[CTL_EN_BIT])  state_d = CTL_ON;
            CTL_ON:  if (wr_en && !wr_data[CTL_EN_BIT]) state_d = CTL_OFF;
            default: state_d = CTL_OFF;
        endcase
    end

    // Outputs
    always_comb begin
        enabled    = (state_q == CTL_ON);
        rd_data    = '0;
        rd_data[CTL_EN_BIT] = enabled;
        flush_all  = (wr_en && wr_data[CTL_CLR_ALL_BIT]) || icache_inv;
        flush_user = wr_en && wr_data[CTL_CLR_USER_BIT];
    end

    assert_readback_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (rd_data == {{(CTL_W-1){1'b0}}, $past(wr_data[CTL_EN_BIT])}));

    assert_hold_state_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(enabled));
endmodule

// File: rtl/btc_array.sv
module btc_array #(
    parameter int AW    = 32,
    parameter int IDX_W = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          up_valid,
    input  logic [AW-1:0] up_addr,
    input  logic [AW-1:0] up_target,
    input  logic          up_taken,
    input  logic          up_user,
    input  logic          flush_all,
    input  logic          flush_user,
    input  logic [AW-1:0] lk_addr,
    output logic          rd_valid,
    output logic [AW-IDX_W-3:0] rd_tag,
    output logic [AW-1:0] rd_target
);
    localparam int ENTRIES = 1 << IDX_W;
    localparam int TAG_LO  = IDX_W + 2;
    localparam int TAG_W   = AW - TAG_LO;

    logic [ENTRIES-1:0] valid_q;
    logic [ENTRIES-1:0] user_q;
    logic [TAG_W-1:0]   tag_q [ENTRIES];
    logic [AW-1:0]      tgt_q [ENTRIES];

    logic [IDX_W-1:0] up_idx;
    logic [TAG_W-1:0] up_tag;
    logic [IDX_W-1:0] lk_idx;
    logic             unused_low_bits;

    assign up_idx = up_addr[TAG_LO-1:2];
    assign up_tag = up_addr[AW-1:TAG_LO];
    assign lk_idx = lk_addr[TAG_LO-1:2];
    assign unused_low_bits = ^{up_addr[1:0], lk_addr[1:0], lk_addr[AW-1:TAG_LO]};

    for (genvar i = 0; i < ENTRIES; i++) begin : g_entry
        logic sel;
        logic v_upd;
        logic u_upd;
        assign sel = up_valid && (up_idx == IDX_W'(i));

        always_comb begin
            v_upd = valid_q[i];
            u_upd = user_q[i];
            if (sel && up_taken) begin
                v_upd = 1'b1;
                u_upd = up_user;
            end else if (sel && valid_q[i] && (tag_q[i] == up_tag)) begin
                v_upd = 1'b0;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                valid_q[i] <= 1'b0;
                user_q[i]  <= 1'b0;
                tag_q[i]   <= '0;
                tgt_q[i]   <= '0;
            end else begin
                user_q[i]  <= u_upd;
                valid_q[i] <= v_upd && !flush_all && !(flush_user && u_upd);
                if (sel && up_taken) begin
                    tag_q[i] <= up_tag;
                    tgt_q[i] <= up_target;
                end
            end
        end
    end

    assign rd_valid  = valid_q[lk_idx];
    assign rd_tag    = tag_q[lk_idx];
    assign rd_target = tgt_q[lk_idx];

    assert_clear_all_R4: assert property (@(posedge clk) disable iff (!rst_n)
        flush_all |=> (valid_q == '0));

    assert_clear_user_R5: assert property (@(posedge clk) disable iff (!rst_n)
        flush_user |=> ((valid_q & user_q) == '0));

    assert_keep_super_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_user && !flush_all && !up_valid) |=>
            ((valid_q & ~user_q) == $past(valid_q & ~user_q)));

    assert_alloc_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (up_valid && up_taken && !flush_all && !flush_user) |=>
            valid_q[$past(up_idx)]);
endmodule

// File: rtl/btc_lookup.sv
module btc_lookup #(
    parameter int AW    = 32,
    parameter int IDX_W = 4
) (
    input  logic          enabled,
    input  logic          inv_now,
    input  logic          lk_valid,
    input  logic [AW-1:0] lk_addr,
    input  logic          rd_valid,
    input  logic [AW-IDX_W-3:0] rd_tag,
    input  logic [AW-1:0] rd_target,
    output logic          hit,
    output logic [AW-1:0] target
);
    localparam int TAG_LO = IDX_W + 2;

    logic tag_eq;
    logic unused_lk_low;

    assign unused_lk_low = ^lk_addr[TAG_LO-1:0];
    assign tag_eq = (rd_tag == lk_addr[AW-1:TAG_LO]);

    always_comb begin
        hit    = lk_valid && enabled && !inv_now && rd_valid && tag_eq;
        target = hit ? rd_target : '0;
    end

    always_comb begin
        assert_no_hit_when_off_R2: assert (!(hit && !enabled));
    end
endmodule

// File: rtl/btc_ctrl.sv
module btc_ctrl
    import btc_pkg::*;
#(
    parameter int AW    = 32,
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_wr_en,
    input  logic [CTL_W-1:0] ctl_wr_data,
    output logic [CTL_W-1:0] ctl_rd_data,
    input  logic             icache_inv,
    input  logic             lk_valid,
    input  logic [AW-1:0]    lk_addr,
    output logic             lk_hit,
    output logic [AW-1:0]    lk_target,
    input  logic             up_valid,
    input  logic [AW-1:0]    up_addr,
    input  logic [AW-1:0]    up_target,
    input  logic             up_taken,
    input  logic             up_user
);
    localparam int TAG_W = AW - IDX_W - 2;

    logic             enabled;
    logic             flush_all;
    logic             flush_user;
    logic             rd_valid;
    logic [TAG_W-1:0] rd_tag;
    logic [AW-1:0]    rd_target;

    btc_ctl u_ctl (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (ctl_wr_en),
        .wr_data    (ctl_wr_data),
        .icache_inv (icache_inv),
        .enabled    (enabled),
        .flush_all  (flush_all),
        .flush_user (flush_user),
        .rd_data    (ctl_rd_data)
    );

    btc_array #(.AW(AW), .IDX_W(IDX_W)) u_array (
        .clk        (clk),
        .rst_n      (rst_n),
        .up_valid   (up_valid),
        .up_addr    (up_addr),
        .up_target  (up_target),
        .up_taken   (up_taken),
        .up_user    (up_user),
        .flush_all  (flush_all),
        .flush_user (flush_user),
        .lk_addr    (lk_addr),
        .rd_valid   (rd_valid),
        .rd_tag     (rd_tag),
        .rd_target  (rd_target)
    );

    btc_lookup #(.AW(AW), .IDX_W(IDX_W)) u_lookup (
        .enabled   (enabled),
        .inv_now   (flush_all || flush_user),
        .lk_valid  (lk_valid),
        .lk_addr   (lk_addr),
        .rd_valid  (rd_valid),
        .rd_tag    (rd_tag),
        .rd_target (rd_target),
        .hit       (lk_hit),
        .target    (lk_target)
    );

    assert_disabled_miss_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_rd_data[CTL_EN_BIT] |-> !lk_hit);

    assert_collide_miss_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (icache_inv || (ctl_wr_en && (ctl_wr_data[CTL_CLR_ALL_BIT] || ctl_wr_data[CTL_CLR_USER_BIT])))
            |-> !lk_hit);

    assert_icinv_flush_R8: assert property (@(posedge clk) disable iff (!rst_n)
        icache_inv |=> !lk_hit);
endmodule

// File: tb/btc_ctrl_test.sv
module btc_ctrl_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctl_wr_en = 1'b0;
    logic [2:0]  ctl_wr_data = '0;
    logic [2:0]  ctl_rd_data;
    logic        icache_inv = 1'b0;
    logic        lk_valid = 1'b0;
    logic [31:0] lk_addr = '0;
    logic        lk_hit;
    logic [31:0] lk_target;
    logic        up_valid = 1'b0;
    logic [31:0] up_addr = '0;
    logic [31:0] up_target = '0;
    logic        up_taken = 1'b0;
    logic        up_user = 1'b0;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    logic        m_en;
    logic        m_valid [16];
    logic        m_user  [16];
    logic [25:0] m_tag   [16];
    logic [31:0] m_tgt   [16];

    always #(CLK_PERIOD/2) clk = ~clk;

    btc_ctrl uut (
        .clk(clk), .rst_n(rst_n),
        .ctl_wr_en(ctl_wr_en), .ctl_wr_data(ctl_wr_data), .ctl_rd_data(ctl_rd_data),
        .icache_inv(icache_inv),
        .lk_valid(lk_valid), .lk_addr(lk_addr), .lk_hit(lk_hit), .lk_target(lk_target),
        .up_valid(up_valid), .up_addr(up_addr), .up_target(up_target),
        .up_taken(up_taken), .up_user(up_user)
    );

    function automatic logic exp_hit();
        logic inv;
        logic [3:0] ix;
        inv = icache_inv || (ctl_wr_en && (ctl_wr_data[1] || ctl_wr_data[2]));
        ix  = lk_addr[5:2];
        return lk_valid && m_en && !inv && m_valid[ix] && (m_tag[ix] == lk_addr[31:6]);
    endfunction

    function automatic logic [31:0] mk_addr(input int tag, input int ix);
        return (32'(tag) << 6) | (32'(ix) << 2);
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic model_edge();
        logic [3:0] ix;
        ix = up_addr[5:2];
        if (up_valid) begin
            if (up_taken) begin
                m_valid[ix] = 1'b1; m_user[ix] = up_user;
                m_tag[ix] = up_addr[31:6]; m_tgt[ix] = up_target;
            end else if (m_valid[ix] && m_tag[ix] == up_addr[31:6]) begin
                m_valid[ix] = 1'b0;
            end
        end
        for (int i = 0; i < 16; i++) begin
            if (icache_inv || (ctl_wr_en && ctl_wr_data[1])) m_valid[i] = 1'b0;
            if (ctl_wr_en && ctl_wr_data[2] && m_user[i]) m_valid[i] = 1'b0;
        end
        if (ctl_wr_en) m_en = ctl_wr_data[0];
    endtask

    // one cycle: drive at negedge, check combinational outputs, advance model
    task automatic cyc(input logic wr, input logic [2:0] wd, input logic inv,
                       input logic lkv, input logic [31:0] lka,
                       input logic upv, input logic [31:0] upa, input logic [31:0] upt,
                       input logic tk, input logic usr, input string req);
        logic eh;
        @(negedge clk);
        ctl_wr_en = wr; ctl_wr_data = wd; icache_inv = inv;
        lk_valid = lkv; lk_addr = lka;
        up_valid = upv; up_addr = upa; up_target = upt; up_taken = tk; up_user = usr;
        #1;
        eh = exp_hit();
        check(req, 32'(lk_hit), 32'(eh));
        if (eh) check(req, lk_target, m_tgt[lka[5:2]]);
        check("R6", 32'(ctl_rd_data), {31'b0, m_en});
        model_edge();
    endtask

    task automatic look(input logic [31:0] a, input string req);
        cyc(0, 3'b000, 0, 1, a, 0, 0, 0, 0, 0, req);
    endtask

    task automatic alloc(input logic [31:0] a, input logic [31:0] t, input logic usr);
        cyc(0, 3'b000, 0, 0, 0, 1, a, t, 1, usr, "R10");
    endtask

    initial begin
        int seed;
        seed = $urandom(32'd5150);
        m_en = 1'b0;
        for (int i = 0; i < 16; i++) begin
            m_valid[i] = 0; m_user[i] = 0; m_tag[i] = '0; m_tgt[i] = '0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        check("R1", 32'(ctl_rd_data), 32'd0);
        check("R1", 32'(lk_hit), 32'd0);

        // R2 disabled: allocate, no prediction
        alloc(mk_addr(1, 3), 32'h1000_0000, 0);
        look(mk_addr(1, 3), "R2");
        // R7 enable + clear-all together
        cyc(1, 3'b011, 0, 0, 0, 0, 0, 0, 0, 0, "R7");
        look(mk_addr(1, 3), "R7");
        check("R7", 32'(lk_hit), 32'd0);
        alloc(mk_addr(1, 3), 32'h1000_0004, 0);
        look(mk_addr(1, 3), "R10");
        check("R10", 32'(lk_hit), 32'd1);
        // R6 write clear-user only, readback of bits 2:1 stays zero
        alloc(mk_addr(2, 4), 32'h2000_0000, 1);
        cyc(1, 3'b101, 0, 1, mk_addr(1, 3), 0, 0, 0, 0, 0, "R9");
        look(mk_addr(1, 3), "R5");
        check("R5", 32'(lk_hit), 32'd1);
        look(mk_addr(2, 4), "R5");
        check("R5", 32'(lk_hit), 32'd0);
        // R3 tag mismatch at same index
        look(mk_addr(3, 3), "R3");
        // R11 not-taken with wrong tag has no effect, then matching retires
        cyc(0, 3'b000, 0, 0, 0, 1, mk_addr(2, 3), 0, 0, 0, "R11");
        look(mk_addr(1, 3), "R11");
        check("R11", 32'(lk_hit), 32'd1);
        cyc(0, 3'b000, 0, 0, 0, 1, mk_addr(1, 3), 0, 0, 0, "R11");
        look(mk_addr(1, 3), "R11");
        check("R11", 32'(lk_hit), 32'd0);
        // R8 + R9 + R12 invalidate pulse with lookup and update
        alloc(mk_addr(0, 7), 32'h3000_0000, 0);
        cyc(0, 3'b000, 1, 1, mk_addr(0, 7), 1, mk_addr(0, 8), 32'h4, 1, 0, "R9");
        look(mk_addr(0, 7), "R8");
        look(mk_addr(0, 8), "R12");
        // R12 clear-user with supervisor update keeps it
        cyc(1, 3'b101, 0, 0, 0, 1, mk_addr(0, 9), 32'h9, 1, 0, "R12");
        look(mk_addr(0, 9), "R12");
        check("R12", 32'(lk_hit), 32'd1);
        // R2 disable again
        cyc(1, 3'b000, 0, 1, mk_addr(0, 9), 0, 0, 0, 0, 0, "R2");
        look(mk_addr(0, 9), "R2");
        cyc(1, 3'b001, 0, 0, 0, 0, 0, 0, 0, 0, "R2");

        // constrained random
        for (int n = 0; n < 4000; n++) begin
            logic wr, inv, lkv, upv;
            logic [2:0] wd;
            wr  = ($urandom % 100) < 4;
            wd  = ($urandom % 100) < 85 ? {($urandom % 2 == 0), ($urandom % 3 == 0), 1'b1}
                                        : 3'($urandom);
            inv = ($urandom % 100) < 3;
            lkv = ($urandom % 100) < 80;
            upv = ($urandom % 100) < 50;
            cyc(wr, wd, inv, lkv, mk_addr($urandom % 4, $urandom % 16),
                upv, mk_addr($urandom % 4, $urandom % 16), $urandom,
                ($urandom % 4) != 0, $urandom % 2, "R3");
        end

        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule